// File: doc/BRIEF.md
# Looping Instruction Dock Controller

This block steers the instruction stream of one dock in a dataflow processor. Micro-instructions arrive one per handshake at an entry stage. They pass a two-state hatch into a circular instruction queue. They come out one at a time into an on-deck register, and from there they are offered to an external executor. The executor answers with a completion strobe. A tail instruction closes the hatch. While the hatch is closed, every on-deck instruction that belongs to an outer loop writes a copy of itself back into the queue, so a block of instructions repeats on its own until the outer counter runs out.

The outer counter lives inside the controller. A set-outer instruction updates it when that instruction completes. When an instruction reaches on-deck with the counter at zero, the controller reopens the hatch, pulses an inner-counter clear and drops the instruction without offering it. The one exception is a set-outer that is not part of a loop. A kill instruction does not go through the hatch. It waits at the entry stage until an unarmored instruction is being offered, then aborts it and forces the outer counter to zero.

The on-deck sequencer has four named states. IDLE waits for the queue and pops it (IDLE to EVAL). EVAL decides between discarding (EVAL to DRAIN) and offering (EVAL to EXEC). EXEC offers the word until completion or kill (EXEC to DRAIN). DRAIN waits until any pending copy has been written (DRAIN to IDLE). The hatch has two states, OPEN and SEALED. A tail moves it from OPEN to SEALED. A discard moves it from SEALED to OPEN.

Top module: `dock_ctrl`

## Requirements
- R1: After reset the hatch is open, the outer counter is 0, nothing is offered to the executor, and an ordinary instruction sees in_ready high.
- R2: Word layout: bit 36 is armor, bit 35 is the outer-loop mark (OL), bits 34:33 are a predicate that is passed through unchanged, and bits 32:30 are the kind (0 ordinary, 1 tail, 2 kill, 3 set-outer). For set-outer, bit 29 set means decrement with saturation at 0; bit 29 clear means load the low OC_W bits. A tail is always accepted, closes the hatch, and is never offered to the executor.
- R3: While the hatch is sealed, ordinary and set-outer instructions see in_ready low.
- R4: The queue accepts entry instructions in order. When it holds DEPTH entries, in_ready is low for ordinary instructions.
- R5: If the outer counter is 0 when an instruction reaches on-deck, and that instruction is not a set-outer with OL clear, the controller pulses inner_clr for one cycle, opens the hatch and never offers the instruction.
- R6: An instruction with OL set that reaches on-deck while the counter is nonzero writes one copy of itself into the queue once the hatch is sealed and a slot is free. A block of N such instructions, closed by a tail and counted down by a set-outer, is therefore offered in its original order once per counter value.
- R7: An instruction with OL clear is offered exactly once.
- R8: An offered word stays on ex_word with ex_valid high until ex_done or a kill. On-deck is vacated only after both the execution and any pending copy have finished.
- R9: A kill is accepted only while an unarmored instruction is being offered. An armored instruction runs to completion with the kill held back.
- R10: An accepted kill pulses ex_abort, sets the outer counter to 0 and ends the offer. The instruction is not offered again.
- R11: If a kill and ex_done meet in the same cycle, the kill wins: a set-outer aborted this way does not load the counter.
- R12: When a set-outer completes, the outer counter takes the loaded literal or its saturating decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry instruction present |
| in_word | input | 37 | Entry instruction word |
| in_ready | output | 1 | Entry instruction taken this cycle |
| ex_valid | output | 1 | On-deck instruction offered to executor |
| ex_word | output | 37 | Offered instruction word |
| ex_done | input | 1 | Executor reports completion |
| ex_abort | output | 1 | Offered instruction killed this cycle |
| inner_clr | output | 1 | Inner counter clear on discard |
| hatch_sealed | output | 1 | Hatch state, 1 when sealed |
| outer_count | output | OC_W | Outer loop counter |

## Verification
The sequencer is driven with these patterns:
- A lone instruction at counter zero separates discard from execution.
- A three-word loop closed by a tail and counted down from 3 shows whether recirculation keeps order and stops on the exact count, including the draining discards of leftover copies.
- A held executor with a full queue separates back-pressure from loss.
- An armored word followed by an unarmored set-outer, with a kill waiting behind them, shows that armor blocks the kill and that the kill beats a simultaneous completion.
- A kill against a looping word shows that its pending copy still lands and is then discarded.

// File: rtl/dock_pkg.sv
package dock_pkg;
    localparam int IW      = 37;
    localparam int ARMOR_B = 36;
    localparam int OL_B    = 35;
    localparam int KIND_HI = 32;
    localparam int KIND_LO = 30;
    localparam int DEC_B   = 29;

    typedef enum logic [2:0] {
        K_WORK   = 3'd0,
        K_TAIL   = 3'd1,
        K_KILL   = 3'd2,
        K_SETOUT = 3'd3
    } kind_e;

    typedef enum logic [1:0] {
        OD_IDLE,
        OD_EVAL,
        OD_EXEC,
        OD_DRAIN
    } od_state_e;

    typedef enum logic {
        H_OPEN   = 1'b0,
        H_SEALED = 1'b1
    } hatch_e;

    function automatic logic [2:0] kind_of(input logic [IW-1:0] w);
        return w[KIND_HI:KIND_LO];
    endfunction
endpackage

// File: rtl/dock_hatch.sv
module dock_hatch
    import dock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seal_req,
    input  logic unseal_req,
    output logic sealed
);
    hatch_e state, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= H_OPEN;
        else        state <= state_n;
    end

    // a tail arriving together with a discard leaves the hatch sealed
    always_comb begin
        state_n = state;
        unique case (state)
            H_OPEN:   if (seal_req) state_n = H_SEALED;
            H_SEALED: if (unseal_req && !seal_req) state_n = H_OPEN;
            default:  state_n = H_OPEN;
        endcase
        sealed = (state == H_SEALED);
    end
endmodule

// File: rtl/dock_ififo.sv
module dock_ififo
    import dock_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_data,
    input  logic          rd_en,
    output logic [IW-1:0] rd_data,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [IW-1:0] slots [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_wr, do_rd;

    assign full    = (cnt == CAP);
    assign empty   = (cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = slots[rp];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) slots[wp] <= wr_data;
    end
endmodule

// File: rtl/dock_ondeck.sv
module dock_ondeck
    import dock_pkg::*;
#(
    parameter int OC_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_empty,
    input  logic            q_full,
    input  logic [IW-1:0]   q_data,
    output logic            q_pop,
    input  logic            hatch_sealed,
    output logic            dup_wr,
    output logic            unseal_req,
    input  logic            kill_pending,
    output logic            kill_take,
    output logic            ex_valid,
    output logic [IW-1:0]   od_word,
    input  logic            ex_done,
    output logic            ex_abort,
    output logic            inner_clr,
    output logic [OC_W-1:0] outer_count
);
    od_state_e     state, state_n;
    logic          dup_pend;
    logic          od_ol, od_armor, od_setout, od_exempt, oc_zero;
    logic          discard;
    logic          load_word, set_dup, fin_set, fin_kill;

    assign od_ol     = od_word[OL_B];
    assign od_armor  = od_word[ARMOR_B];
    assign od_setout = (kind_of(od_word) == K_SETOUT);
    assign od_exempt = od_setout && !od_ol;
    assign oc_zero   = (outer_count == '0);
    assign discard   = oc_zero && !od_exempt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OD_IDLE;
        else        state <= state_n;
    end

    // next state and outputs
    always_comb begin
        state_n    = state;
        q_pop      = 1'b0;
        load_word  = 1'b0;
        set_dup    = 1'b0;
        ex_valid   = 1'b0;
        kill_take  = 1'b0;
        ex_abort   = 1'b0;
        inner_clr  = 1'b0;
        unseal_req = 1'b0;
        fin_set    = 1'b0;
        fin_kill   = 1'b0;
        dup_wr     = dup_pend && hatch_sealed && !q_full;
        unique case (state)
            OD_IDLE: begin
                if (!q_empty) begin
                    q_pop     = 1'b1;
                    load_word = 1'b1;
                    state_n   = OD_EVAL;
                end
            end
            OD_EVAL: begin
                set_dup = od_ol && !oc_zero;
                if (discard) begin
                    inner_clr  = 1'b1;
                    unseal_req = 1'b1;
                    state_n    = OD_DRAIN;
                end else begin
                    state_n = OD_EXEC;
                end
            end
            OD_EXEC: begin
                ex_valid = 1'b1;
                if (kill_pending && !od_armor) begin
                    kill_take = 1'b1;
                    ex_abort  = 1'b1;
                    fin_kill  = 1'b1;
                    state_n   = OD_DRAIN;
                end else if (ex_done) begin
                    fin_set = od_setout;
                    state_n = OD_DRAIN;
                end
            end
            OD_DRAIN: begin
                if (!dup_pend || dup_wr) state_n = OD_IDLE;
            end
            default: state_n = OD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (load_word) od_word <= q_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dup_pend    <= 1'b0;
            outer_count <= '0;
        end else begin
            if (set_dup)     dup_pend <= 1'b1;
            else if (dup_wr) dup_pend <= 1'b0;
            if (fin_kill) begin
                outer_count <= '0;
            end else if (fin_set) begin
                if (od_word[DEC_B]) outer_count <= oc_zero ? '0 : outer_count - 1'b1;
                else                outer_count <= od_word[OC_W-1:0];
            end
        end
    end
endmodule

// File: rtl/dock_ctrl.sv
module dock_ctrl
    import dock_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int OC_W  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [IW-1:0]   in_word,
    output logic            in_ready,
    output logic            ex_valid,
    output logic [IW-1:0]   ex_word,
    input  logic            ex_done,
    output logic            ex_abort,
    output logic            inner_clr,
    output logic            hatch_sealed,
    output logic [OC_W-1:0] outer_count
);
    logic          in_tail, in_kill;
    logic          q_full, q_empty, q_pop, q_wr;
    logic [IW-1:0] q_wdata, q_rdata;
    logic          dup_wr, unseal_req, kill_take, entry_wr;

    assign in_tail  = (kind_of(in_word) == K_TAIL);
    assign in_kill  = (kind_of(in_word) == K_KILL);
    assign entry_wr = in_valid && !in_tail && !in_kill && !hatch_sealed && !q_full;
    assign in_ready = in_tail ? 1'b1 : (in_kill ? kill_take : (!hatch_sealed && !q_full));

    // copies are written only while sealed, entries only while open
    assign q_wr    = entry_wr || dup_wr;
    assign q_wdata = dup_wr ? ex_word : in_word;

    dock_hatch u_hatch (
        .clk        (clk),
        .rst_n      (rst_n),
        .seal_req   (in_valid && in_tail),
        .unseal_req (unseal_req),
        .sealed     (hatch_sealed)
    );

    dock_ififo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (q_wr),
        .wr_data (q_wdata),
        .rd_en   (q_pop),
        .rd_data (q_rdata),
        .full    (q_full),
        .empty   (q_empty)
    );

    dock_ondeck #(.OC_W(OC_W)) u_od (
        .clk          (clk),
        .rst_n        (rst_n),
        .q_empty      (q_empty),
        .q_full       (q_full),
        .q_data       (q_rdata),
        .q_pop        (q_pop),
        .hatch_sealed (hatch_sealed),
        .dup_wr       (dup_wr),
        .unseal_req   (unseal_req),
        .kill_pending (in_valid && in_kill),
        .kill_take    (kill_take),
        .ex_valid     (ex_valid),
        .od_word      (ex_word),
        .ex_done      (ex_done),
        .ex_abort     (ex_abort),
        .inner_clr    (inner_clr),
        .outer_count  (outer_count)
    );
endmodule

// File: rtl/dock_ctrl_chk.sv
module dock_ctrl_chk
    import dock_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int OC_W  = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [IW-1:0]   in_word,
    input logic            in_ready,
    input logic            ex_valid,
    input logic [IW-1:0]   ex_word,
    input logic            ex_done,
    input logic            ex_abort,
    input logic            inner_clr,
    input logic            hatch_sealed,
    input logic [OC_W-1:0] outer_count
);
    logic in_tail, in_kill, in_plain;
    assign in_tail  = (kind_of(in_word) == K_TAIL);
    assign in_kill  = (kind_of(in_word) == K_KILL);
    assign in_plain = !in_tail && !in_kill;

    // R2
    tail_seals_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_tail |=> hatch_sealed);

    // R3
    sealed_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_plain && hatch_sealed |-> !in_ready);

    // R5
    discard_unseals_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inner_clr && !(in_valid && in_tail) |=> !hatch_sealed);

    // R5
    discard_not_offered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inner_clr |-> !ex_valid);

    // R8
    offer_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && !ex_done && !ex_abort |=> ex_valid && $stable(ex_word));

    // R9
    kill_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_kill && in_ready |-> ex_valid && !ex_word[ARMOR_B]);

    // R10
    kill_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_abort |=> outer_count == '0 && !ex_valid);

    // R12
    load_outer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid && ex_done && !ex_abort && kind_of(ex_word) == K_SETOUT && !ex_word[DEC_B]
        |=> outer_count == $past(ex_word[OC_W-1:0]));
endmodule

bind dock_ctrl dock_ctrl_chk #(.DEPTH(DEPTH), .OC_W(OC_W)) u_chk (.*);

// File: tb/dock_ctrl_tb.sv
`timescale 1ns/1ps
module dock_ctrl_tb;
    import dock_pkg::*;
    localparam int DEPTH = 8;
    localparam int OC_W  = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [IW-1:0]   in_word = '0;
    logic            in_ready;
    logic            ex_valid;
    logic [IW-1:0]   ex_word;
    logic            ex_done = 1'b0;
    logic            ex_abort;
    logic            inner_clr;
    logic            hatch_sealed;
    logic [OC_W-1:0] outer_count;

    always #2 clk = ~clk;

    dock_ctrl #(.DEPTH(DEPTH), .OC_W(OC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .ex_valid(ex_valid), .ex_word(ex_word),
        .ex_done(ex_done), .ex_abort(ex_abort), .inner_clr(inner_clr),
        .hatch_sealed(hatch_sealed), .outer_count(outer_count)
    );

    int checks = 0;
    int errors = 0;
    int n_clr = 0;
    int n_abort = 0;
    logic hold = 1'b0;
    logic seen = 1'b0;
    logic [IW-1:0] exp_q [$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] mk(input bit armor, input bit ol, input logic [2:0] kind,
                                         input logic [29:0] low);
        return {armor, ol, 2'b11, kind, low};
    endfunction

    task automatic send(input logic [IW-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // scoreboard monitor and executor model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (inner_clr) n_clr++;
                if (ex_abort) n_abort++;
                if (ex_done) begin
                    ex_done = 1'b0;
                end else if (ex_valid) begin
                    if (!seen) begin
                        seen = 1'b1;
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R7 R8 unexpected offer", 64'(ex_word), 64'h0);
                        end else begin
                            logic [IW-1:0] w;
                            w = exp_q.pop_front();
                            chk(ex_word == w, "R6 R7 offer order", 64'(ex_word), 64'(w));
                        end
                    end
                    if (!hold) ex_done = 1'b1;
                end
                if (!ex_valid) seen = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 64'h0, 64'h1);
        report();
        $finish;
    end

    initial begin
        logic [IW-1:0] wa, wb, wd, wx, we, wc, kill_w, tail_w;
        kill_w = mk(0, 0, K_KILL, 30'h0);
        tail_w = mk(0, 0, K_TAIL, 30'h0);

        repeat (3) @(negedge clk);
        chk(hatch_sealed == 1'b0, "R1 hatch open", 64'(hatch_sealed), 64'h0);
        chk(outer_count == '0, "R1 counter zero", 64'(outer_count), 64'h0);
        chk(ex_valid == 1'b0, "R1 no offer", 64'(ex_valid), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        in_word = mk(0, 0, K_WORK, 30'h1);
        in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R1 entry ready", 64'(in_ready), 64'h1);
        in_valid = 1'b0;

        // R5: ordinary word at counter zero is dropped
        send(mk(0, 0, K_WORK, 30'h1));
        repeat (10) @(negedge clk);
        chk(n_clr == 1, "R5 discard pulse", 64'(n_clr), 64'h1);
        chk(hatch_sealed == 1'b0, "R5 hatch open", 64'(hatch_sealed), 64'h0);

        // R12: set-outer with OL clear is exempt and loads 3
        exp_q.push_back(mk(0, 0, K_SETOUT, 30'd3));
        send(mk(0, 0, K_SETOUT, 30'd3));
        repeat (10) @(negedge clk);
        chk(outer_count == 6'd3, "R12 literal load", 64'(outer_count), 64'h3);

        // R6: three-word loop, counted down from 3
        wa = mk(0, 1, K_WORK, 30'hA);
        wb = mk(0, 1, K_WORK, 30'hB);
        wd = mk(0, 1, K_SETOUT, 30'h2000_0000);
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(wa);
            exp_q.push_back(wb);
            exp_q.push_back(wd);
        end
        send(wa);
        send(wb);
        send(wd);
        send(tail_w);
        @(negedge clk);
        in_word = mk(0, 0, K_WORK, 30'h77);
        in_valid = 1'b1;
        #1;
        chk(hatch_sealed == 1'b1, "R2 tail seals", 64'(hatch_sealed), 64'h1);
        chk(in_ready == 1'b0, "R3 sealed blocks entry", 64'(in_ready), 64'h0);
        in_valid = 1'b0;
        repeat (120) @(negedge clk);
        chk(exp_q.size() == 0, "R6 loop offers complete", 64'(exp_q.size()), 64'h0);
        chk(outer_count == '0, "R12 decrement to zero", 64'(outer_count), 64'h0);
        chk(n_clr == 4, "R5 leftover copies dropped", 64'(n_clr), 64'h4);
        chk(hatch_sealed == 1'b0, "R5 discard reopens hatch", 64'(hatch_sealed), 64'h0);

        // R4, R7, R8: full queue behind a held word
        exp_q.push_back(mk(0, 0, K_SETOUT, 30'd1));
        send(mk(0, 0, K_SETOUT, 30'd1));
        repeat (8) @(negedge clk);
        hold = 1'b1;
        wx = mk(0, 0, K_WORK, 30'h100);
        exp_q.push_back(wx);
        send(wx);
        for (int i = 0; i < DEPTH + 1; i++) exp_q.push_back(mk(0, 0, K_WORK, 30'(i + 'h200)));
        for (int i = 0; i < DEPTH; i++) send(mk(0, 0, K_WORK, 30'(i + 'h200)));
        @(negedge clk);
        in_word = mk(0, 0, K_WORK, 30'(DEPTH + 'h200));
        in_valid = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R4 full queue blocks", 64'(in_ready), 64'h0);
        chk(ex_valid && ex_word == wx, "R8 offer held", 64'(ex_word), 64'(wx));
        in_valid = 1'b0;
        hold = 1'b0;
        send(mk(0, 0, K_WORK, 30'(DEPTH + 'h200)));
        repeat (80) @(negedge clk);
        chk(exp_q.size() == 0, "R4 R7 every word once", 64'(exp_q.size()), 64'h0);
        chk(outer_count == 6'd1, "R7 counter untouched", 64'(outer_count), 64'h1);

        // R9, R11: armored word shields, kill beats completion of set-outer
        hold = 1'b1;
        wd = mk(1, 0, K_WORK, 30'h300);
        we = mk(0, 0, K_SETOUT, 30'd5);
        exp_q.push_back(wd);
        exp_q.push_back(we);
        send(wd);
        send(we);
        fork
            send(kill_w);
        join_none
        repeat (6) @(negedge clk);
        #1;
        chk(in_ready == 1'b0, "R9 kill held back", 64'(in_ready), 64'h0);
        chk(n_abort == 0, "R9 armored not aborted", 64'(n_abort), 64'h0);
        chk(ex_valid && ex_word == wd, "R9 armored still offered", 64'(ex_word), 64'(wd));
        hold = 1'b0;
        repeat (30) @(negedge clk);
        chk(n_abort == 1, "R10 abort pulse", 64'(n_abort), 64'h1);
        chk(outer_count == '0, "R11 kill beats done", 64'(outer_count), 64'h0);
        chk(exp_q.size() == 0, "R9 both offered", 64'(exp_q.size()), 64'h0);

        // R10: kill against a looping word, copy discarded afterwards
        exp_q.push_back(mk(0, 0, K_SETOUT, 30'd2));
        send(mk(0, 0, K_SETOUT, 30'd2));
        repeat (8) @(negedge clk);
        hold = 1'b1;
        wc = mk(0, 1, K_WORK, 30'h400);
        exp_q.push_back(wc);
        send(wc);
        send(tail_w);
        send(kill_w);
        hold = 1'b0;
        repeat (40) @(negedge clk);
        chk(n_abort == 2, "R10 second abort", 64'(n_abort), 64'h2);
        chk(outer_count == '0, "R10 counter forced zero", 64'(outer_count), 64'h0);
        chk(n_clr == 5, "R10 copy dropped", 64'(n_clr), 64'h5);
        chk(hatch_sealed == 1'b0, "R5 hatch reopened", 64'(hatch_sealed), 64'h0);
        chk(exp_q.size() == 0, "R10 no re-offer", 64'(exp_q.size()), 64'h0);

        report();
        $finish;
    end
endmodule